// File: doc/BRIEF.md
# Line-Count Block Transfer Engine

This block moves blocks of data between a memory and a network FIFO pair. Each transfer is measured in lines of 32 bytes. There are two independent channels. The transmit channel reads lines from memory and presents them to the transmit FIFO. The receive channel takes words from the receive FIFO and writes them into memory.

Software starts a channel with a single command write that carries a start address and a line count. A select bit picks the channel: the upper-word location for transmit, the lower-word location for receive. Each line moves as four 64-bit beats over a request/grant memory port. A beat moves only while the FIFO side can take or supply data, so FIFO throttling stalls the channel without losing its position. Each channel raises its own sticky done flag when its last beat has moved.

An occupancy counter records how many cycles the engine has held the memory bus. It can be cleared, and it can be paused.

Top module: `lcx_engine`

## Requirements
- R1: A command whose line count is below 2 or above 512 sets that channel's error flag and does not start the channel. No memory request follows from it. Counts from 2 to 512 inclusive start the channel in the cycle after the command.
- R2: A command with `cmd_tx`=1 starts the transmit channel and one with `cmd_tx`=0 starts the receive channel. The channels run and report independently, and a command to one leaves the other's flags unchanged.
- R3: Each line is four 64-bit beats. The first beat address is `cmd_addr` with its low 5 bits cleared, and each later beat adds 8. Transmit beats are reads (`mem_we`=0) and receive beats are writes (`mem_we`=1).
- R4: A channel moves exactly `lines*4` beats. In the cycle after the last beat, busy clears and done sets. This holds even when throttling stalls the channel just before its last beat.
- R5: A beat moves only on a cycle with `mem_req` and `mem_gnt` both high. A read is requested only while `tx_ready` is high, and a write only while `rx_valid` is high.
- R6: Done and error flags stay set until the next accepted command to the same channel. A command to a busy channel is ignored: its address and count are discarded, and the flags are left unchanged.
- R7: When both channels can move a beat in the same cycle, the receive write takes the memory port.
- R8: `occ_count` adds one on every cycle with `mem_req` and `mem_gnt` high while `occ_en` is high. It holds while `occ_en` is low. `occ_clr` zeroes it and overrides counting.
- R9: After reset all busy, done and error flags are 0, `mem_req` is 0 and `occ_count` is 0.
- R10: On a granted read, `tx_valid` is high and `tx_data` equals `mem_rdata`. On a granted write, `rx_ready` is high and `mem_wdata` equals `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_tx | input | 1 | 1 = transmit command location, 0 = receive command location |
| cmd_addr | input | 32 | Start byte address (low 5 bits ignored) |
| cmd_lines | input | 10 | Line count |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Grant; the beat moves this cycle |
| mem_rdata | input | 64 | Read data, valid with grant |
| tx_valid | output | 1 | Transmit FIFO data valid |
| tx_data | output | 64 | Transmit FIFO data |
| tx_ready | input | 1 | Transmit FIFO can accept (throttle when low) |
| rx_valid | input | 1 | Receive FIFO has data (throttle when low) |
| rx_data | input | 64 | Receive FIFO data |
| rx_ready | output | 1 | Receive FIFO pop |
| tx_busy | output | 1 | Transmit channel active |
| tx_done | output | 1 | Transmit finished (sticky) |
| tx_err | output | 1 | Transmit count rejected (sticky) |
| rx_busy | output | 1 | Receive channel active |
| rx_done | output | 1 | Receive finished (sticky) |
| rx_err | output | 1 | Receive count rejected (sticky) |
| occ_en | input | 1 | Occupancy counter enable |
| occ_clr | input | 1 | Occupancy counter clear |
| occ_count | output | 32 | Bus-occupancy cycle count |

## Verification
Several properties are checked on every cycle:
- Beats move only for a busy channel.
- No read is requested against a throttled transmit FIFO, and no write against an empty receive FIFO.
- The two FIFO strobes are never high together.
- The final beat always turns busy into done, a rejected count always yields error without busy, and a command to a busy channel never disturbs its pointer.
- The counter holds, steps and clears as specified.

Only the bench scenarios can show the rest:
- The full beat address sequence and the data on each beat.
- The exact beat total after stalls placed right before the last beat.
- That a discarded command leaves no trace in the address stream.
- That flags stay sticky across the other channel's activity.
- The occupancy total after a known transfer.

// File: rtl/lcx_pkg.sv
package lcx_pkg;
  localparam int LINE_BYTES = 32;
  localparam int MIN_LINES  = 2;
  localparam int MAX_LINES  = 512;
  localparam int LINE_SH    = $clog2(LINE_BYTES);
endpackage

// File: rtl/lcx_rstsync.sv
module lcx_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lcx_occ.sv
module lcx_occ #(
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          tick,
  output logic [OW-1:0] cnt
);
  logic [OW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = clr | (en & tick);
    cnt_d  = clr ? '0 : cnt_q + OW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_OCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q)); // R8
  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !clr) |=> (cnt_q == $past(cnt_q) + OW'(1))); // R8
  AST_OCC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/lcx_chan.sv
module lcx_chan #(
  parameter int AW        = 32,
  parameter int LW        = 10,
  parameter int BEAT_SH   = 3,
  parameter int LINE_SH   = 5,
  parameter int MIN_LINES = 2,
  parameter int MAX_LINES = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_lines,
  input  logic          fire,
  output logic [AW-1:0] beat_addr,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int BPL_SH = LINE_SH - BEAT_SH;
  localparam int RW     = LW + BPL_SH;
  localparam int PW     = AW - BEAT_SH;

  logic [PW-1:0] ptr_q, ptr_d;
  logic [RW-1:0] rem_q, rem_d;
  logic          busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic          in_range, ld_ok, ld_bad, step, upd;

  always_comb begin
    in_range = (cmd_lines >= LW'(MIN_LINES)) && (cmd_lines <= LW'(MAX_LINES));
    ld_ok    = start && !busy_q && in_range;
    ld_bad   = start && !busy_q && !in_range;
    step     = fire && busy_q;
    upd      = start | fire;
    ptr_d    = ptr_q;
    rem_d    = rem_q;
    busy_d   = busy_q;
    done_d   = done_q;
    err_d    = err_q;
    if (ld_ok) begin
      ptr_d  = {cmd_addr[AW-1:LINE_SH], {BPL_SH{1'b0}}};
      rem_d  = {cmd_lines, {BPL_SH{1'b0}}};
      busy_d = 1'b1;
      done_d = 1'b0;
      err_d  = 1'b0;
    end else if (ld_bad) begin
      done_d = 1'b0;
      err_d  = 1'b1;
    end else if (step) begin
      ptr_d = ptr_q + PW'(1);
      rem_d = rem_q - RW'(1);
      if (rem_q == RW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (upd) begin
      ptr_q  <= ptr_d;
      rem_q  <= rem_d;
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign beat_addr = {ptr_q, {BEAT_SH{1'b0}}};
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;

  AST_FIRE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> busy_q); // R5
  AST_STOP_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fire && rem_q == RW'(1)) |=> (done_q && !busy_q)); // R4
  AST_BAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && !in_range) |=> (err_q && !busy_q)); // R1
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !fire) |=> ($stable(rem_q) && $stable(ptr_q))); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && busy_q)); // R6
endmodule

// File: rtl/lcx_engine.sv
module lcx_engine #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int LW = 10,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_tx,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_lines,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_busy,
  output logic          tx_done,
  output logic          tx_err,
  output logic          rx_busy,
  output logic          rx_done,
  output logic          rx_err,
  input  logic          occ_en,
  input  logic          occ_clr,
  output logic [OW-1:0] occ_count
);
  import lcx_pkg::*;

  localparam int BEAT_SH = $clog2(DW / 8);

  logic          srst_n;
  logic          tx_want, rx_want, tx_sel, rx_sel;
  logic          tx_fire, rx_fire, owned;
  logic [AW-1:0] tx_addr, rx_addr;

  lcx_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lcx_chan #(
    .AW(AW), .LW(LW), .BEAT_SH(BEAT_SH), .LINE_SH(LINE_SH),
    .MIN_LINES(MIN_LINES), .MAX_LINES(MAX_LINES)
  ) u_tx (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (cmd_wr & cmd_tx),
    .cmd_addr  (cmd_addr),
    .cmd_lines (cmd_lines),
    .fire      (tx_fire),
    .beat_addr (tx_addr),
    .busy      (tx_busy),
    .done      (tx_done),
    .err       (tx_err)
  );

  lcx_chan #(
    .AW(AW), .LW(LW), .BEAT_SH(BEAT_SH), .LINE_SH(LINE_SH),
    .MIN_LINES(MIN_LINES), .MAX_LINES(MAX_LINES)
  ) u_rx (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (cmd_wr & ~cmd_tx),
    .cmd_addr  (cmd_addr),
    .cmd_lines (cmd_lines),
    .fire      (rx_fire),
    .beat_addr (rx_addr),
    .busy      (rx_busy),
    .done      (rx_done),
    .err       (rx_err)
  );

  always_comb begin
    rx_want   = rx_busy & rx_valid;
    tx_want   = tx_busy & tx_ready;
    rx_sel    = rx_want;
    tx_sel    = tx_want & ~rx_want;
    mem_req   = rx_want | tx_want;
    mem_we    = rx_sel;
    mem_addr  = rx_sel ? rx_addr : tx_addr;
    mem_wdata = rx_data;
    owned     = mem_req & mem_gnt;
    rx_fire   = rx_sel & mem_gnt;
    tx_fire   = tx_sel & mem_gnt;
    rx_ready  = rx_fire;
    tx_valid  = tx_fire;
    tx_data   = mem_rdata;
  end

  lcx_occ #(.OW(OW)) u_occ (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (occ_en),
    .clr   (occ_clr),
    .tick  (owned),
    .cnt   (occ_count)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!srst_n)
    !(tx_valid && rx_ready)); // R7
  AST_RX_WINS: assert property (@(posedge clk) disable iff (!srst_n)
    tx_valid |-> !(rx_busy && rx_valid)); // R7
  AST_TX_THROTTLE: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_req && !mem_we) |-> tx_ready); // R5
  AST_RX_THROTTLE: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_req && mem_we) |-> rx_valid); // R5
endmodule

// File: tb/lcx_engine_tb.sv
module lcx_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr, cmd_tx;
  logic [31:0] cmd_addr;
  logic [9:0]  cmd_lines;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata, tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic        tx_busy, tx_done, tx_err, rx_busy, rx_done, rx_err;
  logic        occ_en, occ_clr;
  logic [31:0] occ_count;

  int          vectors = 0;
  int          fails   = 0;
  bit          mon_on  = 0;
  bit          thr_mode = 0;
  bit          gnt_f = 0, txr_f = 0, rxv_f = 0;
  bit          rx_hs = 0;
  logic [31:0] rx_seq = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] tx_eaddr = 0, rx_eaddr = 0;
  int          tx_beats = 0, rx_beats = 0;

  always #10 clk = ~clk;

  function automatic logic [63:0] mdl(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_1234};
  endfunction

  assign mem_rdata = mdl(mem_addr);
  assign rx_data   = {32'hC0DE_0000, rx_seq};

  lcx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_tx(cmd_tx),
    .cmd_addr(cmd_addr), .cmd_lines(cmd_lines), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_busy(tx_busy),
    .tx_done(tx_done), .tx_err(tx_err), .rx_busy(rx_busy),
    .rx_done(rx_done), .rx_err(rx_err), .occ_en(occ_en),
    .occ_clr(occ_clr), .occ_count(occ_count)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Stimulus driver for the handshake inputs
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rx_hs) begin
        rx_seq = rx_seq + 1;
        rx_hs  = 0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (thr_mode) begin
        mem_gnt  = lfsr[0] | lfsr[7];
        tx_ready = lfsr[3] | lfsr[9];
        rx_valid = lfsr[5] | lfsr[12];
      end else begin
        mem_gnt  = gnt_f;
        tx_ready = txr_f;
        rx_valid = rxv_f;
      end
    end
  end

  // Mid-cycle monitor of every beat
  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_req && !mem_we)
        chk(tx_ready == 1'b1, "R5 read requested while tx throttled", 64'(tx_ready), 64'd1);
      if (mem_req && mem_we)
        chk(rx_valid == 1'b1, "R5 write requested while rx empty", 64'(rx_valid), 64'd1);
      if (tx_busy && rx_busy && tx_ready && rx_valid && mem_gnt)
        chk(rx_ready && !tx_valid, "R7 receive priority", {62'd0, rx_ready, tx_valid}, 64'd2);
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          chk(mem_addr == rx_eaddr, "R3 rx beat address", 64'(mem_addr), 64'(rx_eaddr));
          chk(rx_ready && mem_wdata == rx_data, "R10 rx write data", mem_wdata, rx_data);
          rx_eaddr = rx_eaddr + 8;
          rx_beats++;
          rx_hs = 1;
        end else begin
          chk(mem_addr == tx_eaddr, "R3 tx beat address", 64'(mem_addr), 64'(tx_eaddr));
          chk(tx_valid && tx_data == mdl(mem_addr), "R10 tx read data", tx_data, mdl(mem_addr));
          tx_eaddr = tx_eaddr + 8;
          tx_beats++;
        end
      end
    end
  end

  task automatic run_cmd(input bit tx, input logic [31:0] a, input logic [9:0] n);
    @(posedge clk);
    #3;
    cmd_wr = 1; cmd_tx = tx; cmd_addr = a; cmd_lines = n;
    @(posedge clk);
    #3;
    cmd_wr = 0;
  endtask

  task automatic wait_done(input bit tx, input string tag);
    int n = 0;
    while (!(tx ? tx_done : rx_done) && n < 40000) begin
      @(negedge clk);
      n++;
    end
    #1;
    chk(n < 40000, tag, 64'(n), 64'd40000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({tx_busy, tx_done, tx_err, rx_busy, rx_done, rx_err, mem_req} == 7'd0,
        "R9 flags after reset",
        64'({tx_busy, tx_done, tx_err, rx_busy, rx_done, rx_err, mem_req}), 64'd0);
    chk(occ_count == 0, "R9 counter after reset", 64'(occ_count), 64'd0);
  endtask

  task automatic t_xfer(input bit tx, input logic [31:0] a, input int lines, input bit thr);
    thr_mode = thr;
    gnt_f = 1; txr_f = 1; rxv_f = 1;
    if (tx) begin tx_eaddr = a & 32'hFFFF_FFE0; tx_beats = 0; end
    else    begin rx_eaddr = a & 32'hFFFF_FFE0; rx_beats = 0; end
    run_cmd(tx, a, 10'(lines));
    wait_done(tx, "R4 transfer completes");
    chk(tx ? (tx_beats == lines * 4) : (rx_beats == lines * 4), "R4 beat total",
        64'(tx ? tx_beats : rx_beats), 64'(lines * 4));
    chk(tx ? !tx_busy : !rx_busy, "R4 busy clears at done", 64'(tx ? tx_busy : rx_busy), 64'd0);
    repeat (5) @(negedge clk);
    #1;
    chk(!mem_req && (tx ? tx_beats : rx_beats) == lines * 4, "R4 no beats after done",
        64'(tx ? tx_beats : rx_beats), 64'(lines * 4));
    chk((tx ? tx_eaddr : rx_eaddr) == (a & 32'hFFFF_FFE0) + 32'(lines * 32),
        "R3 final address span", 64'(tx ? tx_eaddr : rx_eaddr),
        64'((a & 32'hFFFF_FFE0) + 32'(lines * 32)));
    thr_mode = 0;
  endtask

  task automatic t_bad_counts();
    logic [9:0] bad [4] = '{10'd0, 10'd1, 10'd513, 10'd1023};
    gnt_f = 1; txr_f = 1; rxv_f = 1;
    foreach (bad[i]) begin
      run_cmd(1, 32'h2000, bad[i]);
      @(negedge clk);
      chk(tx_err && !tx_busy && !mem_req && !tx_done, "R1 tx count rejected",
          64'({tx_err, tx_busy, mem_req, tx_done}), 64'h8);
    end
    run_cmd(0, 32'h3000, 10'd1);
    @(negedge clk);
    chk(rx_err && !rx_busy && !mem_req, "R1 rx count rejected",
        64'({rx_err, rx_busy, mem_req}), 64'h4);
    chk(tx_err, "R2 tx error untouched by rx command", 64'(tx_err), 64'd1);
    repeat (4) @(negedge clk);
    chk(tx_err && rx_err, "R6 error flags sticky", 64'({tx_err, rx_err}), 64'h3);
    t_xfer(1, 32'h0000_4000, 2, 0);
    chk(!tx_err && tx_done, "R1 minimum count accepted, error cleared",
        64'({tx_err, tx_done}), 64'h1);
    chk(rx_err, "R2 rx error untouched by tx transfer", 64'(rx_err), 64'd1);
  endtask

  task automatic t_busy_ignore();
    gnt_f = 1; txr_f = 0; rxv_f = 1;
    tx_eaddr = 32'h1000; tx_beats = 0;
    run_cmd(1, 32'h1000, 10'd2);
    @(negedge clk);
    chk(tx_busy && !tx_done, "R6 new command clears done", 64'({tx_busy, tx_done}), 64'h2);
    run_cmd(1, 32'h8000, 10'd9);
    run_cmd(1, 32'h9000, 10'd0);
    @(negedge clk);
    chk(tx_busy && !tx_err && tx_beats == 0, "R6 busy channel ignores command",
        64'({tx_busy, tx_err}), 64'h2);
    txr_f = 1;
    wait_done(1, "R6 stalled transfer completes");
    chk(tx_beats == 8, "R6 ignored command adds no beats", 64'(tx_beats), 64'd8);
    repeat (10) @(negedge clk);
    chk(tx_done, "R6 done sticky", 64'(tx_done), 64'd1);
    t_xfer(0, 32'h0002_0005, 3, 0);
    chk(tx_done && rx_done, "R2 tx done kept across rx transfer",
        64'({tx_done, rx_done}), 64'h3);
  endtask

  task automatic t_both();
    gnt_f = 1; txr_f = 0; rxv_f = 1;
    tx_eaddr = 32'h0005_0000; tx_beats = 0;
    rx_eaddr = 32'h0006_0000; rx_beats = 0;
    run_cmd(1, 32'h0005_0000, 10'd4);
    run_cmd(0, 32'h0006_0000, 10'd2);
    @(posedge clk);
    #3;
    txr_f = 1;
    wait_done(0, "R7 rx completes under contention");
    wait_done(1, "R7 tx completes after rx");
    chk(tx_beats == 16 && rx_beats == 8, "R2 independent totals",
        64'({tx_beats[15:0], rx_beats[15:0]}), 64'h0010_0008);
  endtask

  task automatic t_stall_last();
    gnt_f = 1; txr_f = 1; rxv_f = 1;
    tx_eaddr = 32'h0007_0000; tx_beats = 0;
    run_cmd(1, 32'h0007_0000, 10'd2);
    while (tx_beats < 6) begin
      @(posedge clk);
      #5;
    end
    txr_f = 0;
    repeat (6) @(negedge clk);
    #1;
    chk(tx_busy && !tx_done && tx_beats == 7, "R4 stalled before last beat",
        64'(tx_beats), 64'd7);
    txr_f = 1;
    wait_done(1, "R4 resumes to done");
    repeat (3) @(negedge clk);
    #1;
    chk(tx_beats == 8, "R4 exact total after final stall", 64'(tx_beats), 64'd8);
  endtask

  task automatic t_occ();
    @(posedge clk); #3; occ_clr = 1;
    @(posedge clk); #3; occ_clr = 0;
    chk(occ_count == 0, "R8 clear", 64'(occ_count), 64'd0);
    occ_en = 1;
    t_xfer(1, 32'h0008_0000, 3, 0);
    chk(occ_count == 12, "R8 counts owned cycles", 64'(occ_count), 64'd12);
    occ_en = 0;
    t_xfer(0, 32'h0009_0000, 2, 0);
    chk(occ_count == 12, "R8 holds when disabled", 64'(occ_count), 64'd12);
    occ_en = 1;
    @(posedge clk); #3; occ_clr = 1;
    @(posedge clk); #3; occ_clr = 0; occ_en = 0;
    chk(occ_count == 0, "R8 clear overrides enable", 64'(occ_count), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_wr = 0; cmd_tx = 0; cmd_addr = 0; cmd_lines = 0;
    mem_gnt = 0; tx_ready = 0; rx_valid = 0; occ_en = 0; occ_clr = 0;
    repeat (3) @(posedge clk);
    #3;
    rst_n = 1;
    repeat (3) @(posedge clk);
    t_reset();
    mon_on = 1;
    t_xfer(1, 32'h0000_1234, 5, 0);
    t_xfer(0, 32'h0001_001F, 4, 0);
    t_bad_counts();
    t_busy_ignore();
    t_both();
    t_stall_last();
    t_xfer(1, 32'h0010_0000, 512, 1);
    t_xfer(0, 32'h0020_0040, 37, 1);
    t_xfer(1, 32'h0030_0000, 2, 1);
    t_occ();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule